// File: doc/BRIEF.md
# Multi-Channel Event Timer

A memory-mapped timer block built around one free-running 64-bit up-counter and a set of comparator channels. Software drives it over a plain 32-bit register bus with separate write and read strobes. Read data is registered and appears one cycle after the read strobe. Each channel compares the counter with its own comparator. It fires once, or every N ticks in periodic mode. A firing sets that channel's bit in a shared status register. The result is then signalled in one of two ways: as a level on one of several routed interrupt lines, or as a posted message (a data word plus an address) on a strobe output.

A channel can be narrowed to 32-bit matching, which wraps at 2^32. Periodic channels take their first match value and their period through a two-write handshake. A global option moves channels 0 and 1 off their routed lines and onto two dedicated outputs, a system tick and a real-time-clock interrupt. Channel count, number of interrupt lines, tick period and per-channel capabilities are parameters.

Top module: `evtimer`

## Requirements
- R1: The counter (low word at 0x0F0, high word at 0x0F4) advances by exactly one per clock while the enable bit (bit 0 of the global control word at 0x010) is set. It holds its value while that bit is clear. Writes to the counter words take effect only while the counter is halted and are dropped while it runs.
- R2: Read data reflects the addressed register at the clock edge where the read strobe is sampled. It holds until the next read. Reading any register, including the counter, changes no state.
- R3: The word at 0x000 reports the channel count minus one in bits [12:8] and the legacy-routing capability in bit 15. All other bits of that word read zero. The word at 0x004 returns the tick period in femtoseconds.
- R4: Channel n's control word sits at 0x800 + 32*n and has these bits:
  - bit 0: enable
  - bit 1: periodic
  - bit 2: load handshake
  - bit 3: 32-bit mode
  - bit 4: message enable
  - bit 5: periodic capable (read-only)
  - bit 6: message capable (read-only)
  - bits [8 +: log2(lines)]: interrupt line

  On a channel without periodic capability, bits 1 and 2 are ignored and read zero. On a channel without message capability, bit 4 is ignored and reads zero.
- R5: Outside the load handshake, comparator writes (low word at +0x08, high word at +0x0C) read back exactly as written.
- R6: In 64-bit mode an enabled channel fires only when all 64 counter bits equal the comparator. Its status bit is set one cycle after the counter shows the matching value.
- R7: In 32-bit mode only the low 32 bits are compared, and matching wraps modulo 2^32. If the target is already behind the counter's low word, the channel stays silent until the counter wraps round to it.
- R8: With the load handshake bit set on a periodic channel, the first low-word comparator write loads the match value. The next low-word write loads the period, and the handshake bit then clears itself. High-word writes go to the match value or the period in the same phase.
- R9: Each periodic match advances the comparator by the stored period, so successive firings are exactly one period apart.
- R10: The status register at 0x020 holds one bit per channel (bit n = channel n). Writing 1 to a bit clears it; writing 0 leaves it unchanged.
- R11: A set status bit drives the interrupt line chosen by its channel's line field, unless message enable is set for that channel, in which case no line is driven.
- R12: A firing with message enable set raises msg_valid one cycle after the status bit is set. It carries the channel's message data (+0x10) and message address (+0x14). When several channels are waiting, the lowest-numbered goes first, one per cycle.
- R13: With legacy routing on (bit 1 at 0x010), channel 0's interrupt appears on legacy_tick and channel 1's on legacy_rtc, and neither channel drives its routed line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_lines | output | NUM_LINES | Routed interrupt levels |
| legacy_tick | output | 1 | Channel 0 interrupt in legacy routing |
| legacy_rtc | output | 1 | Channel 1 interrupt in legacy routing |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench builds the block with three channels, eight interrupt lines and legacy routing available. Only channels 0 and 2 are given periodic and message capability. Channel 1 therefore shows the ignored control bits reading zero, and channels 0 and 2 can fire messages in the same cycle to exercise the ordering. With eight lines the three-bit line field is fully used. Preloading the counter near 2^32 puts the 32-bit wrap within a few tens of cycles.

// File: rtl/evtimer.sv
module evtimer #(
  parameter int NUM_CH = 3,
  parameter int NUM_LINES = 8,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
  parameter int unsigned PER_CAP = 32'h5,
  parameter int unsigned MSG_CAP = 32'h5,
  parameter bit LEGACY_CAP = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [11:0]          addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_LINES-1:0] irq_lines,
  output logic                 legacy_tick,
  output logic                 legacy_rtc,
  output logic                 msg_valid,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data
);
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [NUM_CH-1:0] PCAP = PER_CAP[NUM_CH-1:0];
  localparam logic [NUM_CH-1:0] MCAP = MSG_CAP[NUM_CH-1:0];
  localparam bit LEG_OK = LEGACY_CAP && (NUM_CH >= 2);

  localparam logic [11:0] A_ID = 12'h000, A_PER = 12'h004, A_GCFG = 12'h010,
                          A_STAT = 12'h020, A_CLO = 12'h0F0, A_CHI = 12'h0F4;
  localparam logic [4:0]  O_CFG = 5'h00, O_CLO = 5'h08, O_CHI = 5'h0C,
                          O_RD = 5'h10, O_RA = 5'h14;

  logic              gen_en, legacy;
  logic [63:0]       cnt;
  logic [NUM_CH-1:0] ch_en, ch_per, ch_sv, sv_phase, ch_f32, ch_msg;
  logic [NUM_CH-1:0] status, pend, fire, lvl, chsel, grant;
  logic [LW-1:0]     ch_route [NUM_CH];
  logic [63:0]       cmp [NUM_CH];
  logic [63:0]       prd [NUM_CH];
  logic [31:0]       rt_data [NUM_CH];
  logic [31:0]       rt_addr [NUM_CH];
  logic [31:0]       rmux;
  logic [CW-1:0]     gidx;

  assign lvl         = status & ~ch_msg;
  assign grant       = pend & (~pend + 1'b1);
  assign legacy_tick = legacy & lvl[0];
  assign legacy_rtc  = legacy & lvl[1];

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      chsel[i] = addr[11] && (addr[10:5] == 6'(i));
      fire[i]  = gen_en && ch_en[i] &&
                 (ch_f32[i] ? (cnt[31:0] == cmp[i][31:0]) : (cnt == cmp[i]));
    end
  end

  always_comb begin
    gidx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pend[i]) gidx = CW'(i);
  end

  always_comb begin
    irq_lines = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (lvl[i] && !(legacy && i < 2) && (int'(ch_route[i]) < NUM_LINES))
        irq_lines[ch_route[i]] = 1'b1;
  end

  always_comb begin
    rmux = '0;
    case (addr)
      A_ID:   rmux = {16'h0, LEG_OK, 2'b00, 5'(NUM_CH - 1), 8'h00};
      A_PER:  rmux = PERIOD_FS;
      A_GCFG: rmux = {30'b0, legacy, gen_en};
      A_STAT: rmux = 32'(status);
      A_CLO:  rmux = cnt[31:0];
      A_CHI:  rmux = cnt[63:32];
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (chsel[i]) begin
        case (addr[4:0])
          O_CFG: begin
            rmux[0] = ch_en[i];
            rmux[1] = ch_per[i];
            rmux[2] = ch_sv[i];
            rmux[3] = ch_f32[i];
            rmux[4] = ch_msg[i];
            rmux[5] = PCAP[i];
            rmux[6] = MCAP[i];
            rmux[8 +: LW] = ch_route[i];
          end
          O_CLO: rmux = cmp[i][31:0];
          O_CHI: rmux = cmp[i][63:32];
          O_RD:  rmux = rt_data[i];
          O_RA:  rmux = rt_addr[i];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      legacy <= 1'b0;
      cnt <= '0;
      status <= '0;
      pend <= '0;
      msg_valid <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
      rdata <= '0;
      ch_en <= '0;
      ch_per <= '0;
      ch_sv <= '0;
      sv_phase <= '0;
      ch_f32 <= '0;
      ch_msg <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        ch_route[i] <= '0;
        cmp[i] <= '0;
        prd[i] <= '0;
        rt_data[i] <= '0;
        rt_addr[i] <= '0;
      end
    end else begin
      // R1: counting, or preload while halted
      if (gen_en) cnt <= cnt + 64'd1;
      else if (wr_en && addr == A_CLO) cnt[31:0] <= wdata;
      else if (wr_en && addr == A_CHI) cnt[63:32] <= wdata;

      if (wr_en && addr == A_GCFG) begin
        gen_en <= wdata[0];
        legacy <= wdata[1] & LEG_OK;
      end

      // R10: write-one-to-clear, a new firing wins
      status <= (status & ~((wr_en && addr == A_STAT) ? wdata[NUM_CH-1:0] : '0)) | fire;

      // R12: one message per cycle, lowest channel first
      pend <= (pend & ~grant) | (fire & ch_msg);
      msg_valid <= |pend;
      if (|pend) begin
        msg_addr <= rt_addr[gidx];
        msg_data <= rt_data[gidx];
      end

      if (rd_en) rdata <= rmux;

      for (int i = 0; i < NUM_CH; i++) begin
        // R9: periodic advance
        if (fire[i] && ch_per[i]) begin
          if (ch_f32[i]) cmp[i][31:0] <= cmp[i][31:0] + prd[i][31:0];
          else cmp[i] <= cmp[i] + prd[i];
        end
        if (wr_en && chsel[i]) begin
          case (addr[4:0])
            O_CFG: begin
              ch_en[i]    <= wdata[0];
              ch_per[i]   <= wdata[1] & PCAP[i];
              ch_sv[i]    <= wdata[2] & wdata[1] & PCAP[i];
              ch_f32[i]   <= wdata[3];
              ch_msg[i]   <= wdata[4] & MCAP[i];
              ch_route[i] <= wdata[8 +: LW];
              sv_phase[i] <= 1'b0;
            end
            O_CLO: begin
              // R8: handshake, match value then period
              if (ch_sv[i] && sv_phase[i]) begin
                prd[i][31:0] <= wdata;
                ch_sv[i]     <= 1'b0;
                sv_phase[i]  <= 1'b0;
              end else begin
                cmp[i][31:0] <= wdata;
                if (ch_sv[i]) sv_phase[i] <= 1'b1;
              end
            end
            O_CHI: begin
              if (ch_sv[i] && sv_phase[i]) prd[i][63:32] <= wdata;
              else cmp[i][63:32] <= wdata;
            end
            O_RD: rt_data[i] <= wdata;
            O_RA: rt_addr[i] <= wdata;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
  parameter int NUM_CH = 3,
  parameter int unsigned PER_CAP = 32'h5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [11:0]       addr,
  input logic              gen_en,
  input logic              legacy,
  input logic [63:0]       cnt,
  input logic [NUM_CH-1:0] pend,
  input logic              msg_valid,
  input logic              legacy_tick,
  input logic              legacy_rtc,
  input logic [NUM_CH-1:0] ch_per,
  input logic [NUM_CH-1:0] ch_sv,
  input logic [NUM_CH-1:0] sv_phase
);
  localparam logic [NUM_CH-1:0] PCAP = PER_CAP[NUM_CH-1:0];

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en |=> cnt == $past(cnt) + 64'd1);

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !(wr_en && (addr == 12'h0F0 || addr == 12'h0F4))) |=> cnt == $past(cnt));

  p_legacy_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_tick || legacy_rtc) |-> legacy);

  p_msg_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |=> msg_valid);

  p_sv_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sv_phase & ~ch_sv) == '0);

  p_per_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_per & ~PCAP) == '0);
endmodule

bind evtimer evtimer_chk #(.NUM_CH(NUM_CH), .PER_CAP(PER_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .gen_en(gen_en),
  .legacy(legacy), .cnt(cnt), .pend(pend), .msg_valid(msg_valid),
  .legacy_tick(legacy_tick), .legacy_rtc(legacy_rtc), .ch_per(ch_per),
  .ch_sv(ch_sv), .sv_phase(sv_phase)
);

// File: tb/evtimer_test.sv
`timescale 1ns/1ps
module evtimer_test;
  localparam logic [11:0] A_ID = 12'h000, A_PER = 12'h004, A_GCFG = 12'h010,
                          A_STAT = 12'h020, A_CLO = 12'h0F0, A_CHI = 12'h0F4;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, msg_addr, msg_data;
  logic [7:0] irq_lines;
  logic legacy_tick, legacy_rtc, msg_valid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  evtimer #(.NUM_CH(3), .NUM_LINES(8), .PERIOD_FS(32'd10_000_000),
            .PER_CAP(32'h5), .MSG_CAP(32'h5), .LEGACY_CAP(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_lines(irq_lines),
    .legacy_tick(legacy_tick), .legacy_rtc(legacy_rtc),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data));

  function automatic logic [11:0] chad(int ch, int off);
    return 12'(12'h800 + ch * 32 + off);
  endfunction

  function automatic logic [31:0] cfg_exp(int ch, logic [31:0] w);
    logic pc, mc, per, sv, msg;
    pc  = (ch != 1);
    mc  = (ch != 1);
    per = w[1] & pc;
    sv  = w[2] & per;
    msg = w[4] & mc;
    return {21'b0, w[10:8], 1'b0, mc, pc, msg, w[3], sv, per, w[0]};
  endfunction

  function automatic logic sig(int which);
    case (which)
      0: return |irq_lines;
      1: return msg_valid;
      2: return legacy_tick;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic measure(input int which, output int n);
    n = 0;
    while (!sig(which) && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, d2, w, c;
    int n, ch;
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1;
    idle(1);

    // reset state
    chk("R10 reset irq", irq_lines, 0);
    chk("R12 reset msg", msg_valid, 0);
    rd(A_GCFG, d); chk("R1 reset control", d, 0);
    rd(A_CLO, d);  chk("R1 reset counter", d, 0);
    rd(A_STAT, d); chk("R10 reset status", d, 0);

    // R3
    rd(A_ID, d);  chk("R3 id word", d, 32'h0000_8200);
    rd(A_PER, d); chk("R3 period", d, 32'd10_000_000);

    // R1 / R2
    wr(A_CLO, 32'd100); wr(A_CHI, 32'd5);
    rd(A_CLO, d); rd(A_CLO, d2);
    chk("R2 halted read 1", d, 100);
    chk("R2 halted read 2", d2, 100);
    rd(A_CHI, d); chk("R1 high preload", d, 5);
    wr(A_GCFG, 32'h1);
    rd(A_CLO, d); rd(A_CLO, d2);
    chk("R1 running first", d, 100);
    chk("R1 running step", d2, 101);
    wr(A_CLO, 32'd0);
    rd(A_CLO, d); chk("R1 write dropped while running", d, 103);
    wr(A_GCFG, 32'h0);

    // R4 directed: ignored bits on channel 1
    wr(chad(1, 0), 32'h0000_021F);
    rd(chad(1, 0), d); chk("R4 ch1 ignores periodic and message", d, 32'h0000_0209);

    // R4 / R5 random readback
    for (int it = 0; it < 40; it++) begin
      ch = int'($urandom % 3);
      w = $urandom & 32'hFFFF_FFFB;
      wr(chad(ch, 0), w);
      rd(chad(ch, 0), d); chk("R4 config readback", d, cfg_exp(ch, w));
      c = $urandom;
      wr(chad(ch, 8), c);
      rd(chad(ch, 8), d); chk("R5 comparator low", d, c);
      c = $urandom;
      wr(chad(ch, 12), c);
      rd(chad(ch, 12), d); chk("R5 comparator high", d, c);
      c = $urandom;
      wr(chad(ch, 16), c);
      rd(chad(ch, 16), d); chk("R12 message data readback", d, c);
    end
    for (int i = 0; i < 3; i++) wr(chad(i, 0), 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R6 / R11 one-shot on channel 2, line 5
    wr(A_CLO, 32'd1000); wr(A_CHI, 32'd0);
    wr(chad(2, 0), 32'h0000_0501);
    wr(chad(2, 8), 32'd1010); wr(chad(2, 12), 32'd0);
    wr(A_GCFG, 32'h1);
    measure(0, n);
    chk("R6 one-shot latency", n, 11);
    chk("R11 routed line", irq_lines, 8'h20);
    rd(A_STAT, d); chk("R10 status bit", d, 32'h4);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R10 zero write keeps", d, 32'h4);
    wr(A_STAT, 32'h4);
    rd(A_STAT, d); chk("R10 one write clears", d, 32'h0);
    chk("R11 line drops", irq_lines, 8'h00);
    wr(A_GCFG, 32'h0);
    wr(chad(2, 0), 32'h0);

    // R6: 64-bit compare must not match on low word alone
    wr(A_CHI, 32'd1); wr(A_CLO, 32'hFFFF_FFF0);
    wr(chad(0, 0), 32'h0000_0101);
    wr(chad(0, 8), 32'hFFFF_FFF8); wr(chad(0, 12), 32'd0);
    wr(A_GCFG, 32'h1);
    idle(30);
    chk("R6 high word must match", irq_lines, 8'h00);
    wr(A_GCFG, 32'h0);

    // R7 passed target in 32-bit mode
    wr(A_CHI, 32'd1); wr(A_CLO, 32'hFFFF_FFF0);
    wr(chad(0, 0), 32'h0000_0109);
    wr(chad(0, 8), 32'hFFFF_FFE0);
    wr(A_GCFG, 32'h1);
    idle(30);
    chk("R7 passed target silent", irq_lines, 8'h00);
    wr(A_GCFG, 32'h0);

    // R7 wrap in 32-bit mode
    wr(A_CHI, 32'd1); wr(A_CLO, 32'hFFFF_FFF0);
    wr(chad(0, 8), 32'd4);
    wr(A_GCFG, 32'h1);
    measure(0, n);
    chk("R7 wrap latency", n, 21);
    chk("R7 line 1", irq_lines, 8'h02);
    wr(A_GCFG, 32'h0);
    wr(chad(0, 0), 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R13 legacy routing
    wr(A_CLO, 32'd0); wr(A_CHI, 32'd0);
    wr(chad(0, 0), 32'h0000_0301);
    wr(chad(0, 8), 32'd5); wr(chad(0, 12), 32'd0);
    wr(chad(1, 0), 32'h0000_0401);
    wr(chad(1, 8), 32'd8); wr(chad(1, 12), 32'd0);
    wr(A_GCFG, 32'h3);
    measure(2, n);
    chk("R13 tick latency", n, 6);
    idle(2);
    chk("R13 rtc not yet", legacy_rtc, 0);
    idle(1);
    chk("R13 rtc raised", legacy_rtc, 1);
    chk("R13 routed lines quiet", irq_lines, 8'h00);
    wr(A_GCFG, 32'h0);
    chk("R13 lines after legacy off", irq_lines, 8'h18);
    chk("R13 tick after legacy off", legacy_tick, 0);
    wr(chad(0, 0), 32'h0); wr(chad(1, 0), 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R8 / R9 / R12 periodic message channel 0
    wr(A_CLO, 32'd0); wr(A_CHI, 32'd0);
    wr(chad(0, 0), 32'h0000_0017);
    wr(chad(0, 12), 32'd0); wr(chad(0, 8), 32'd20);
    wr(chad(0, 12), 32'd0); wr(chad(0, 8), 32'd7);
    rd(chad(0, 0), d);  chk("R8 handshake bit clears", d, 32'h0000_0073);
    rd(chad(0, 8), d);  chk("R8 match value kept", d, 20);
    wr(chad(0, 16), 32'hDEAD_0000); wr(chad(0, 20), 32'h1000_0040);
    wr(A_GCFG, 32'h1);
    measure(1, n);
    chk("R12 message latency", n, 22);
    chk("R12 message data", msg_data, 32'hDEAD_0000);
    chk("R12 message address", msg_addr, 32'h1000_0040);
    chk("R11 message masks line", irq_lines, 8'h00);
    @(negedge clk);
    n = 1;
    while (!msg_valid && n < 100) begin @(negedge clk); n++; end
    chk("R9 period spacing", n, 7);
    wr(A_GCFG, 32'h0);
    rd(A_STAT, d); chk("R11 status set though masked", d, 32'h1);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R12 ordering
    wr(A_CLO, 32'd0); wr(A_CHI, 32'd0);
    wr(chad(0, 0), 32'h0000_0011);
    wr(chad(0, 8), 32'd10); wr(chad(0, 12), 32'd0);
    wr(chad(0, 16), 32'hA0); wr(chad(0, 20), 32'hB0);
    wr(chad(2, 0), 32'h0000_0011);
    wr(chad(2, 8), 32'd10); wr(chad(2, 12), 32'd0);
    wr(chad(2, 16), 32'hA2); wr(chad(2, 20), 32'hB2);
    wr(A_GCFG, 32'h1);
    measure(1, n);
    chk("R12 first message time", n, 12);
    chk("R12 channel 0 first", msg_data, 32'hA0);
    @(negedge clk);
    chk("R12 second strobe", msg_valid, 1);
    chk("R12 channel 2 second", msg_addr, 32'hB2);
    @(negedge clk);
    chk("R12 strobes end", msg_valid, 0);
    wr(A_GCFG, 32'h0);

    summary();
    $finish;
  end
endmodule